// File: doc/BRIEF.md
# Byte Add, Subtract and Compare Unit with Flag Generation

This block is the arithmetic slice of an accumulator-style processor datapath. It takes two byte operands and the processor's current carry, overflow and half-carry flags. It computes one of three operations: add with carry, subtract with borrow, or compare. Subtraction and compare run on the same adder. The second operand is complemented, and the carry input is chosen to suit the operation.

The arithmetic itself is combinational. The outcome is captured in an output register only in a cycle where the caller asserts `in_valid`, and it appears on the outputs after that clock edge. For add and subtract, a one-cycle write enable is raised toward either the accumulator or a memory write path, as chosen by `dest_mem`. Compare only updates the flags. It writes nothing and carries the incoming overflow and half-carry values through unchanged.

Top module: `addsub_flag_alu`

## Requirements
- R1: While reset is low and in the first cycle after it, the result, all five flags and both write enables read zero.
- R2: With `op` = 0 (add with carry), the result is (A + B + carry_in) mod 256, and C is bit 8 of that 9-bit sum.
- R3: With `op` = 1 (subtract with borrow), B is replaced by its bitwise inverse before it reaches the same adder, and the incoming carry is used unchanged. The result is (A + ~B + carry_in) mod 256, and C is bit 8, which means no borrow.
- R4: For add and subtract, V is set exactly when A + (adder operand) + carry_in falls outside -128..127, with both bytes read as two's-complement signed values.
- R5: For add and subtract, H is set exactly when the low nibble of A, plus the low nibble of the adder operand, plus carry_in, reaches 16 or more.
- R6: With `op` = 2 (compare), the result is (A - B) mod 256 with no carry input used. C is set when A >= B unsigned. V and H take the values of `v_in` and `h_in`.
- R7: For all three operations, N equals bit 7 of the result, and Z is set exactly when the result is zero.
- R8: After an add or subtract, `acc_we` pulses for one cycle when `dest_mem` = 0, and `mem_we` pulses for one cycle when `dest_mem` = 1. Compare raises neither. The two are never high together.
- R9: The outputs change only on the clock edge that samples `in_valid` high. After an edge with `in_valid` low, the result and flags hold their values and both write enables are low.
- R10: `op` = 3 is a reserved code. Even with `in_valid` high, it leaves the result and flags unchanged and raises no write enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Capture strobe for this cycle's operation |
| op | input | 2 | 0 add with carry, 1 subtract with borrow, 2 compare, 3 reserved |
| dest_mem | input | 1 | Destination of add/subtract result: 0 accumulator, 1 memory |
| opnd_a | input | 8 | First operand |
| opnd_b | input | 8 | Second operand |
| c_in | input | 1 | Current carry flag |
| v_in | input | 1 | Current overflow flag |
| h_in | input | 1 | Current half-carry flag |
| result | output | 8 | Registered result byte |
| flag_n | output | 1 | Registered negative flag |
| flag_v | output | 1 | Registered overflow flag |
| flag_h | output | 1 | Registered half-carry flag |
| flag_z | output | 1 | Registered zero flag |
| flag_c | output | 1 | Registered carry flag |
| acc_we | output | 1 | One-cycle accumulator write enable |
| mem_we | output | 1 | One-cycle memory write enable |

## Verification
The assertions assume that the operands, `op`, `dest_mem` and the incoming flags are known, stable values at every edge where `in_valid` is high. The hold checks also assume that `in_valid` itself is never unknown after reset. The bench drives every input half a period before the sampling edge and holds it until the next negative edge. It keeps `in_valid` at a defined level from time zero. The reserved operation code appears only in the directed cases written for it.

// File: rtl/addsub_alu_pkg.sv
package addsub_alu_pkg;

    typedef enum logic [1:0] {
        ALU_OP_ADC  = 2'd0,
        ALU_OP_SBC  = 2'd1,
        ALU_OP_CMP  = 2'd2,
        ALU_OP_IDLE = 2'd3
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic v;
        logic h;
        logic z;
        logic c;
    } alu_flags_t;

endpackage

// File: rtl/alu_operand_prep.sv
import addsub_alu_pkg::*;

module alu_operand_prep #(
    parameter int W = 8
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   b,
    input  logic           c_in,
    output logic [W-1:0]   b_eff,
    output logic           cin_eff,
    output logic           is_arith,
    output logic           is_cmp
);

    always_comb begin
        b_eff    = b;
        cin_eff  = 1'b0;
        is_arith = 1'b0;
        is_cmp   = 1'b0;
        case (op)
            ALU_OP_ADC: begin
                cin_eff  = c_in;
                is_arith = 1'b1;
            end
            ALU_OP_SBC: begin
                b_eff    = ~b;
                cin_eff  = c_in;
                is_arith = 1'b1;
            end
            ALU_OP_CMP: begin
                b_eff    = ~b;
                cin_eff  = 1'b1;
                is_cmp   = 1'b1;
            end
            default: begin
                b_eff    = b;
            end
        endcase
    end

endmodule

// File: rtl/alu_sum_unit.sv
module alu_sum_unit #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b_eff,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         carry,
    output logic         ovf,
    output logic         half
);

    localparam int NIB_W = 4;
    localparam logic [W-1:0] MSB_MASK = {1'b1, {(W-1){1'b0}}};

    logic [W:0]       full;
    logic [W-1:0]     unused_bias_low;
    logic             unused_nib_top;
    logic [NIB_W-1:0] unused_nib_low;

    // unsigned sum: result and carry-out
    assign full  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
    assign sum   = full[W-1:0];
    assign carry = full[W];

    // biased first operand plus sign-extended second: bit W flags signed overflow
    assign {ovf, unused_bias_low} = {1'b0, a ^ MSB_MASK}
                                  + {b_eff[W-1], b_eff}
                                  + {{W{1'b0}}, cin};

    // low nibble of result minus (low nibble of A plus carry): bit NIB_W is the half-carry
    assign {unused_nib_top, half, unused_nib_low} =
          {2'b00, full[NIB_W-1:0]}
        - ({2'b00, a[NIB_W-1:0]} + {{(NIB_W+1){1'b0}}, cin});

endmodule

// File: rtl/addsub_flag_alu.sv
import addsub_alu_pkg::*;

module addsub_flag_alu #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        op,
    input  logic              dest_mem,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic              c_in,
    input  logic              v_in,
    input  logic              h_in,
    output logic [DATA_W-1:0] result,
    output logic              flag_n,
    output logic              flag_v,
    output logic              flag_h,
    output logic              flag_z,
    output logic              flag_c,
    output logic              acc_we,
    output logic              mem_we
);

    typedef struct packed {
        logic [DATA_W-1:0] res;
        alu_flags_t        flg;
        logic              acc_we;
        logic              mem_we;
    } alu_state_t;

    alu_state_t st_d, st_q;

    alu_op_e           op_sel;
    logic [DATA_W-1:0] b_eff;
    logic              cin_eff;
    logic              is_arith;
    logic              is_cmp;
    logic [DATA_W-1:0] sum;
    logic              carry;
    logic              ovf;
    logic              half;

    assign op_sel = alu_op_e'(op);

    alu_operand_prep #(.W(DATA_W)) u_prep (
        .op       (op_sel),
        .b        (opnd_b),
        .c_in     (c_in),
        .b_eff    (b_eff),
        .cin_eff  (cin_eff),
        .is_arith (is_arith),
        .is_cmp   (is_cmp)
    );

    alu_sum_unit #(.W(DATA_W)) u_sum (
        .a     (opnd_a),
        .b_eff (b_eff),
        .cin   (cin_eff),
        .sum   (sum),
        .carry (carry),
        .ovf   (ovf),
        .half  (half)
    );

    always_comb begin
        st_d        = st_q;
        st_d.acc_we = 1'b0;
        st_d.mem_we = 1'b0;
        if (in_valid && (is_arith || is_cmp)) begin
            st_d.res   = sum;
            st_d.flg.n = sum[DATA_W-1];
            st_d.flg.z = (sum == '0);
            st_d.flg.c = carry;
            if (is_arith) begin
                st_d.flg.v  = ovf;
                st_d.flg.h  = half;
                st_d.acc_we = ~dest_mem;
                st_d.mem_we = dest_mem;
            end else begin
                st_d.flg.v  = v_in;
                st_d.flg.h  = h_in;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result = st_q.res;
    assign flag_n = st_q.flg.n;
    assign flag_v = st_q.flg.v;
    assign flag_h = st_q.flg.h;
    assign flag_z = st_q.flg.z;
    assign flag_c = st_q.flg.c;
    assign acc_we = st_q.acc_we;
    assign mem_we = st_q.mem_we;

    assert_we_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({acc_we, mem_we}));

    assert_cmp_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'd2) |=> (!acc_we && !mem_we));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable({flag_n, flag_v, flag_h, flag_z, flag_c})
                       && !acc_we && !mem_we));

    assert_cmp_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'd2) |=> (flag_c == ($past(opnd_a) >= $past(opnd_b))
                                      && flag_v == $past(v_in) && flag_h == $past(h_in)));

    assert_adc_sum_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'd0) |=>
            (result == DATA_W'($past(opnd_a) + $past(opnd_b) + DATA_W'($past(c_in)))));

endmodule

// File: tb/test_addsub_flag_alu.sv
module test_addsub_flag_alu;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [1:0] op = 2'd0;
    logic       dest_mem = 1'b0;
    logic [7:0] opnd_a = 8'd0;
    logic [7:0] opnd_b = 8'd0;
    logic       c_in = 1'b0;
    logic       v_in = 1'b0;
    logic       h_in = 1'b0;
    logic [7:0] result;
    logic       flag_n, flag_v, flag_h, flag_z, flag_c, acc_we, mem_we;

    always #4 clk = ~clk;

    addsub_flag_alu i_addsub_flag_alu (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .dest_mem(dest_mem),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .c_in(c_in), .v_in(v_in), .h_in(h_in),
        .result(result), .flag_n(flag_n), .flag_v(flag_v), .flag_h(flag_h),
        .flag_z(flag_z), .flag_c(flag_c), .acc_we(acc_we), .mem_we(mem_we)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // bench-side model of the registered outputs
    int m_res = 0, m_n = 0, m_v = 0, m_h = 0, m_z = 0, m_c = 0, m_acc = 0, m_mem = 0;

    task automatic chk(string tag, string what, int act, int exp);
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int sgn8(int x);
        return (x >= 128) ? x - 256 : x;
    endfunction

    task automatic apply(int op_i, int a, int b, int cin, int vin, int hin, int dst, int vld);
        int ob;
        int full;
        int s;
        string t_res, t_v, t_h, t_we;
        opnd_a   = 8'(a);
        opnd_b   = 8'(b);
        op       = 2'(op_i);
        c_in     = 1'(cin);
        v_in     = 1'(vin);
        h_in     = 1'(hin);
        dest_mem = 1'(dst);
        in_valid = 1'(vld);
        m_acc = 0;
        m_mem = 0;
        if (vld == 0) begin
            t_res = "R9"; t_v = "R9"; t_h = "R9"; t_we = "R9";
        end else if (op_i == 3) begin
            t_res = "R10"; t_v = "R10"; t_h = "R10"; t_we = "R10";
        end else if (op_i == 2) begin
            t_res = "R6"; t_v = "R6"; t_h = "R6"; t_we = "R8";
            m_res = (a - b) & 255;
            m_c   = (a >= b) ? 1 : 0;
            m_v   = vin;
            m_h   = hin;
        end else begin
            t_res = (op_i == 0) ? "R2" : "R3";
            t_v = "R4"; t_h = "R5"; t_we = "R8";
            ob    = (op_i == 0) ? b : (~b & 255);
            full  = a + ob + cin;
            m_res = full & 255;
            m_c   = full >> 8;
            s     = sgn8(a) + sgn8(ob) + cin;
            m_v   = (s > 127 || s < -128) ? 1 : 0;
            m_h   = (((a & 15) + (ob & 15) + cin) >= 16) ? 1 : 0;
            m_acc = (dst == 0) ? 1 : 0;
            m_mem = (dst == 1) ? 1 : 0;
        end
        if (vld != 0 && op_i != 3) begin
            m_n = (m_res >> 7) & 1;
            m_z = (m_res == 0) ? 1 : 0;
        end
        @(negedge clk);
        n_vec++;
        chk(t_res, "result", int'(result), m_res);
        chk(t_res, "carry", int'(flag_c), m_c);
        chk(t_v, "overflow", int'(flag_v), m_v);
        chk(t_h, "halfcarry", int'(flag_h), m_h);
        chk((vld != 0 && op_i != 3) ? "R7" : t_res, "negative", int'(flag_n), m_n);
        chk((vld != 0 && op_i != 3) ? "R7" : t_res, "zero", int'(flag_z), m_z);
        chk(t_we, "acc_we", int'(acc_we), m_acc);
        chk(t_we, "mem_we", int'(mem_we), m_mem);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (199000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        n_vec++;
        chk("R1", "result in reset", int'(result), 0);
        chk("R1", "flags in reset", int'({flag_n, flag_v, flag_h, flag_z, flag_c}), 0);
        chk("R1", "enables in reset", int'({acc_we, mem_we}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        n_vec++;
        chk("R1", "result after reset", int'(result), 0);
        chk("R1", "flags after reset", int'({flag_n, flag_v, flag_h, flag_z, flag_c}), 0);
        chk("R1", "enables after reset", int'({acc_we, mem_we}), 0);

        // directed corners: R2 signed overflow, R2 carry with zero, R3 borrow, R5 nibble
        apply(0, 8'h7F, 8'h00, 1, 0, 0, 0, 1);
        apply(0, 8'hFF, 8'h01, 0, 0, 0, 1, 1);
        apply(1, 8'h00, 8'h01, 1, 0, 0, 0, 1);
        apply(1, 8'h80, 8'h01, 1, 1, 1, 1, 1);
        apply(0, 8'h0F, 8'h00, 1, 0, 0, 0, 1);

        // R9: valid low after a write, inputs changing
        apply(0, 8'h12, 8'h34, 1, 1, 1, 1, 0);
        apply(2, 8'h00, 8'h00, 0, 1, 1, 0, 0);
        // R10: reserved code with valid high
        apply(0, 8'h40, 8'h40, 0, 0, 0, 0, 1);
        apply(3, 8'h00, 8'h00, 1, 1, 1, 1, 1);
        apply(3, 8'hFF, 8'h01, 0, 0, 1, 0, 1);

        // R2..R5, R7, R8: add and subtract sweep
        for (int o = 0; o < 2; o++)
            for (int a = 0; a < 256; a++)
                for (int b = 0; b < 256; b += 3)
                    for (int ci = 0; ci < 2; ci++)
                        apply(o, a, b, ci, a & 1, (b >> 1) & 1, ((a ^ b) >> 2) & 1, 1);

        // R6, R7, R8: exhaustive compare sweep
        for (int a = 0; a < 256; a++)
            for (int b = 0; b < 256; b++)
                apply(2, a, b, a & 1, (a >> 1) & 1, b & 1, (b >> 7) & 1, 1);

        // R9 once more after a compare
        apply(1, 8'h55, 8'hAA, 1, 0, 1, 1, 0);

        finish_run();
    end

endmodule